// File: doc/BRIEF.md
# Split-Word Interrupt Controller Register File

This block is the register file and source-tracking core of a 64-source I/O interrupt controller, reached over a 32-bit memory-mapped bus. Each 64-bit control vector (mask, trigger select, polarity, message enable, in-service) is exposed as a low and a high 32-bit word. Each word can be read and written on its own, and a write to one word leaves the other word unchanged. A clear word drops pending edge-triggered events, and fixed identification words report the block's identity and version.

Each of the 64 raw inputs is first corrected by its polarity bit. An edge source latches a request on a rising transition of its corrected input. A level source's request follows the corrected input. A single output line is asserted while any request is pending on an unmasked source. The bus responds one cycle after each request with read data and an error flag. The flag reports misaligned, undefined and illegal-direction accesses, none of which change any state.

Top module: `intc_regfile`

## Requirements
- R1: After reset the mask vector is all ones, and the trigger, polarity, message-enable, request and in-service vectors are all zero. `irq_out` and `rsp_valid` are low.
- R2: Only `bus_addr[11:0]` selects a word. Higher address bits have no effect on decoding.
- R3: An access with `bus_addr[1:0]` not zero is rejected. It changes no state, returns zero data and sets `rsp_err`.
- R4: Word offsets: identification 0x000, mask 0x020, message enable 0x040, trigger select 0x060 (bit = 1 means edge), clear 0x080, auto-control A 0x0C0, auto-control B 0x0E0, status 0x3A0, polarity 0x3E0. Each register's low half (sources 0 to 31) sits at the listed offset and its high half (sources 32 to 63) at offset + 4. A write to one half leaves the other half unchanged.
- R5: Mask, message-enable, trigger and polarity words read back the last value written to them.
- R6: A status read returns the in-service bits of that half ANDed with the inverted mask. A status write replaces that half of the in-service vector.
- R7: A clear write is ANDed with the trigger-select vector. The resulting bits are removed from the request and in-service vectors. Level sources are unaffected. A read of the clear word is an error that returns zero.
- R8: The identification low word reads 0x4943_0040 and the high word reads 0x0000_0102. A write to either word is ignored and flagged as an error.
- R9: Both auto-control registers accept writes to either half without storing anything, read back zero, and report no error.
- R10: An access to any other offset is ignored, returns zero and sets `rsp_err`.
- R11: The corrected input is the raw input XOR the polarity bit. An edge source sets its request on a 0-to-1 step of the corrected input and holds it until cleared. A level source's request equals the corrected input. Any source's in-service bit is set on a 0-to-1 step of its corrected input. A set caused by a new step takes priority over a same-cycle clear or status write.
- R12: `irq_out` is the OR of the request vector ANDed with the inverted mask, registered. It reflects any write or input change sampled at an edge immediately after that edge.
- R13: `rsp_valid` is high in the cycle after each `bus_req`. `rsp_rdata` and `rsp_err` belong to that request, and read data reflects the state before any same-edge update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 64 | Raw interrupt source lines |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; low 12 bits decoded |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero on error or write |
| rsp_err | output | 1 | Access rejected |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear or status write that lands in the same cycle as a fresh 0-to-1 step of a corrected input on the same source. That timing decides whether an event is lost, and it needs the input toggle, the polarity state and the bus write to line up exactly. The random phase toggles single input lines and polarity bits while it issues clear and status writes on a narrow set of offsets, so these collisions occur many times. Directed steps before the random phase walk one edge source and one level source through assert, hold and clear, and check the output after each step.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW    = 32;
  localparam int NSRC  = 2 * DW;
  localparam int OFF_W = 12;
  localparam int AW    = 32;
  localparam int NCFG  = 4;

  localparam logic [OFF_W-1:0] OFF_ID    = 12'h000;
  localparam logic [OFF_W-1:0] OFF_MASK  = 12'h020;
  localparam logic [OFF_W-1:0] OFF_MSI   = 12'h040;
  localparam logic [OFF_W-1:0] OFF_TRIG  = 12'h060;
  localparam logic [OFF_W-1:0] OFF_CLR   = 12'h080;
  localparam logic [OFF_W-1:0] OFF_AUTOA = 12'h0C0;
  localparam logic [OFF_W-1:0] OFF_AUTOB = 12'h0E0;
  localparam logic [OFF_W-1:0] OFF_STAT  = 12'h3A0;
  localparam logic [OFF_W-1:0] OFF_POL   = 12'h3E0;

  localparam logic [DW-1:0] CTRL_ID  = 32'h4943_0040;
  localparam logic [DW-1:0] CTRL_VER = 32'h0000_0102;

  localparam int CFG_MASK = 0;
  localparam int CFG_MSI  = 1;
  localparam int CFG_TRIG = 2;
  localparam int CFG_POL  = 3;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_MASK, SEL_MSI, SEL_TRIG,
    SEL_CLR, SEL_AUTO, SEL_STAT, SEL_POL
  } sel_e;

  function automatic sel_e cfg_sel(input int idx);
    case (idx)
      CFG_MASK: cfg_sel = SEL_MASK;
      CFG_MSI:  cfg_sel = SEL_MSI;
      CFG_TRIG: cfg_sel = SEL_TRIG;
      default:  cfg_sel = SEL_POL;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] put_half(input logic [NSRC-1:0] old,
                                               input logic [DW-1:0] w,
                                               input logic hi);
    put_half = hi ? {w, old[DW-1:0]} : {old[NSRC-1:DW], w};
  endfunction

  function automatic logic [DW-1:0] get_half(input logic [NSRC-1:0] v,
                                             input logic hi);
    get_half = hi ? v[NSRC-1:DW] : v[DW-1:0];
  endfunction
endpackage

// File: rtl/intc_addr_decode.sv
module intc_addr_decode
  import intc_pkg::*;
(
  input  logic             req,
  input  logic             we,
  input  logic [OFF_W-1:0] off,
  output sel_e             sel,
  output logic             hi,
  output logic             err
);
  logic [OFF_W-1:0] base;
  logic             misaligned;
  logic             bad_dir;

  assign base       = {off[OFF_W-1:3], 3'b000};
  assign hi         = off[2];
  assign misaligned = |off[1:0];

  always_comb begin
    unique case (base)
      OFF_ID:    sel = SEL_ID;
      OFF_MASK:  sel = SEL_MASK;
      OFF_MSI:   sel = SEL_MSI;
      OFF_TRIG:  sel = SEL_TRIG;
      OFF_CLR:   sel = SEL_CLR;
      OFF_AUTOA: sel = SEL_AUTO;
      OFF_AUTOB: sel = SEL_AUTO;
      OFF_STAT:  sel = SEL_STAT;
      OFF_POL:   sel = SEL_POL;
      default:   sel = SEL_NONE;
    endcase
  end

  assign bad_dir = (we && sel == SEL_ID) || (!we && sel == SEL_CLR);
  assign err     = req && (misaligned || sel == SEL_NONE || bad_dir);
endmodule

// File: rtl/intc_src_core.sv
module intc_src_core
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] trig,
  input  logic            clr_wr,
  input  logic            isr_wr,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] req_d,
  output logic [NSRC-1:0] req_q,
  output logic [NSRC-1:0] isr_q
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] corr;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] clr_bits;
  logic [NSRC-1:0] isr_base;
  logic [NSRC-1:0] isr_d;

  assign corr     = irq_in ^ pol;
  assign rise     = corr & ~prev_q;
  assign clr_bits = clr_wr ? (put_half('0, wdata, wr_hi) & trig) : '0;

  always_comb begin
    req_d    = (trig & ((req_q & ~clr_bits) | rise)) | (~trig & corr);
    isr_base = isr_wr ? put_half(isr_q, wdata, wr_hi) : isr_q;
    isr_d    = (isr_base & ~clr_bits) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= corr;
      req_q  <= req_d;
      isr_q  <= isr_d;
    end
  end

  // R11 / R7: level-source requests track the corrected input, clear or not
  p_level_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(trig)) == ($past(corr) & ~$past(trig))));

  // R7: an edge request that was low and saw no rising step stays low
  p_edge_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig[0] && !req_q[0] && !(corr[0] && !prev_q[0])) |=> !req_q[0]);
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              irq_out
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic unused_addr;
  assign unused_addr = ^bus_addr[ADDR_W-1:OFF_W];

  sel_e sel;
  logic hi;
  logic err;
  logic wr_ok;

  intc_addr_decode u_dec (
    .req (bus_req),
    .we  (bus_we),
    .off (bus_addr[OFF_W-1:0]),
    .sel (sel),
    .hi  (hi),
    .err (err)
  );

  assign wr_ok = bus_req && bus_we && !err;

  logic [NCFG-1:0][NSRC-1:0] cfg_q;
  logic [NCFG-1:0][NSRC-1:0] cfg_d;

  always_comb begin
    for (int i = 0; i < NCFG; i++) begin
      cfg_d[i] = (wr_ok && sel == cfg_sel(i)) ? put_half(cfg_q[i], bus_wdata, hi)
                                              : cfg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= (i == CFG_MASK) ? '1 : '0;
    end else begin
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= cfg_d[i];
    end
  end

  logic [NSRC-1:0] req_d;
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] isr_q;

  intc_src_core u_core (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .irq_in (irq_in),
    .pol    (cfg_q[CFG_POL]),
    .trig   (cfg_q[CFG_TRIG]),
    .clr_wr (wr_ok && sel == SEL_CLR),
    .isr_wr (wr_ok && sel == SEL_STAT),
    .wr_hi  (hi),
    .wdata  (bus_wdata),
    .req_d  (req_d),
    .req_q  (req_q),
    .isr_q  (isr_q)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_ID:   rd_mux = hi ? CTRL_VER : CTRL_ID;
      SEL_MASK: rd_mux = get_half(cfg_q[CFG_MASK], hi);
      SEL_MSI:  rd_mux = get_half(cfg_q[CFG_MSI], hi);
      SEL_TRIG: rd_mux = get_half(cfg_q[CFG_TRIG], hi);
      SEL_POL:  rd_mux = get_half(cfg_q[CFG_POL], hi);
      SEL_STAT: rd_mux = get_half(isr_q & ~cfg_q[CFG_MASK], hi);
      default:  rd_mux = '0;
    endcase
  end

  logic          rsp_valid_q;
  logic          rsp_err_q;
  logic [DW-1:0] rsp_rdata_q;
  logic          irq_q;
  logic [DW-1:0] rdata_d;
  logic          irq_d;

  assign rdata_d = (bus_req && !bus_we && !err) ? rd_mux : '0;
  assign irq_d   = |(req_d & ~cfg_d[CFG_MASK]);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      irq_q       <= 1'b0;
    end else begin
      rsp_valid_q <= bus_req;
      rsp_err_q   <= err;
      rsp_rdata_q <= rdata_d;
      irq_q       <= irq_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign irq_out   = irq_q;

  // R13: every request is answered in the following cycle
  p_rsp_follows_req_r13: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_req |=> rsp_valid);

  // R3: a misaligned request is always flagged
  p_misalign_err_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_req && bus_addr[1:0] != 2'b00) |=> rsp_err);

  // R10: a rejected access never carries data
  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_err |-> (rsp_rdata == '0));

  // R12: the output is never high without a pending request
  p_irq_needs_req_r12: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq_out |-> (|req_q));
endmodule

// File: tb/intc_regfile_test.sv
`timescale 1ns/1ps
module intc_regfile_test;
  localparam int WATCHDOG_NS = 400000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        bus_req;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        irq_out;

  always #2 clk = ~clk;

  intc_regfile uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_out(irq_out)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [63:0] m_mask, m_msi, m_trig, m_pol, m_req, m_isr, m_prev;
  logic        m_irq;
  logic [63:0] cur_irq;
  string       tag_override = "";

  localparam int K_NONE = 0, K_ID = 1, K_MASK = 2, K_MSI = 3, K_TRIG = 4,
                 K_CLR = 5, K_AUTO = 6, K_STAT = 7, K_POL = 8;

  function automatic int kind_of(input logic [11:0] base);
    case (base)
      12'h000: return K_ID;
      12'h020: return K_MASK;
      12'h040: return K_MSI;
      12'h060: return K_TRIG;
      12'h080: return K_CLR;
      12'h0C0, 12'h0E0: return K_AUTO;
      12'h3A0: return K_STAT;
      12'h3E0: return K_POL;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic [31:0] half(input logic [63:0] v, input bit h);
    return h ? v[63:32] : v[31:0];
  endfunction

  function automatic logic [63:0] sethalf(input logic [63:0] v, input logic [31:0] w, input bit h);
    return h ? {w, v[31:0]} : {v[63:32], w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit rq, input bit we, input logic [31:0] a, input logic [31:0] wd);
    logic [11:0] off;
    bit          h, mis, e_err, wok;
    int          k;
    logic [31:0] e_rd;
    logic [63:0] corr, rise, clr, n_req, n_isr, n_mask;
    string       tag;
    off  = a[11:0];
    h    = off[2];
    mis  = (off[1:0] != 2'b00);
    k    = kind_of({off[11:3], 3'b000});
    bus_req = rq; bus_we = we; bus_addr = a; bus_wdata = wd; irq_in = cur_irq;
    e_err = rq && (mis || k == K_NONE || (we && k == K_ID) || (!we && k == K_CLR));
    e_rd  = 32'h0;
    if (mis)                    tag = "R3";
    else if (k == K_NONE)       tag = "R10";
    else if (k == K_ID)         tag = "R8";
    else if (k == K_CLR)        tag = "R7";
    else if (k == K_AUTO)       tag = "R9";
    else if (k == K_STAT)       tag = "R6 R11";
    else if (a[31:12] != 20'h0) tag = "R2";
    else                        tag = "R4 R5";
    if (tag_override != "") tag = tag_override;
    if (rq && !we && !e_err) begin
      case (k)
        K_ID:   e_rd = h ? 32'h0000_0102 : 32'h4943_0040;
        K_MASK: e_rd = half(m_mask, h);
        K_MSI:  e_rd = half(m_msi, h);
        K_TRIG: e_rd = half(m_trig, h);
        K_POL:  e_rd = half(m_pol, h);
        K_STAT: e_rd = half(m_isr & ~m_mask, h);
        default: e_rd = 32'h0;
      endcase
    end
    // model next state
    wok   = rq && we && !e_err;
    corr  = cur_irq ^ m_pol;
    rise  = corr & ~m_prev;
    clr   = (wok && k == K_CLR) ? (sethalf(64'h0, wd, h) & m_trig) : 64'h0;
    n_req = (m_trig & ((m_req & ~clr) | rise)) | (~m_trig & corr);
    n_isr = (((wok && k == K_STAT) ? sethalf(m_isr, wd, h) : m_isr) & ~clr) | rise;
    n_mask = (wok && k == K_MASK) ? sethalf(m_mask, wd, h) : m_mask;
    if (wok && k == K_MSI)  m_msi  = sethalf(m_msi, wd, h);
    if (wok && k == K_TRIG) m_trig = sethalf(m_trig, wd, h);
    if (wok && k == K_POL)  m_pol  = sethalf(m_pol, wd, h);
    m_mask = n_mask; m_req = n_req; m_isr = n_isr; m_prev = corr;
    m_irq  = |(n_req & ~n_mask);
    @(negedge clk);
    check("R13 valid", {31'h0, rsp_valid}, {31'h0, rq});
    if (rq) begin
      check({tag, " err"}, {31'h0, rsp_err}, {31'h0, e_err});
      check({tag, " data"}, rsp_rdata, e_rd);
    end
    check("R11 R12 irq_out", {31'h0, irq_out}, {31'h0, m_irq});
    bus_req = 1'b0;
  endtask

  task automatic idle();
    access(1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  initial begin
    #(WATCHDOG_NS);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] offs [9];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq_in = '0; cur_irq = '0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_mask = '1; m_msi = '0; m_trig = '0; m_pol = '0;
    m_req = '0; m_isr = '0; m_prev = '0; m_irq = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports
    check("R1 irq_out", {31'h0, irq_out}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    tag_override = "R1";
    access(1, 0, 32'h020, 0); access(1, 0, 32'h024, 0);
    access(1, 0, 32'h060, 0); access(1, 0, 32'h3E4, 0);
    access(1, 0, 32'h040, 0); access(1, 0, 32'h3A0, 0);
    tag_override = "";

    // R4 R5: half writes keep the other half
    access(1, 1, 32'h020, 32'h0000_00F0);
    access(1, 0, 32'h024, 0); access(1, 0, 32'h020, 0);
    access(1, 1, 32'h044, 32'hDEAD_BEEF);
    access(1, 0, 32'h040, 0); access(1, 0, 32'h044, 0);

    // R2: high address bits ignored
    access(1, 1, 32'hABCD_E3E4, 32'h0000_0001);
    access(1, 0, 32'h0000_03E4, 0);
    access(1, 0, 32'h5555_53E4, 0);
    access(1, 1, 32'h0000_03E4, 32'h0);

    // R3: misaligned write has no effect
    access(1, 1, 32'h022, 32'hFFFF_FFFF);
    access(1, 0, 32'h020, 0);
    access(1, 0, 32'h3A1, 0);

    // R8: identification words, write rejected
    access(1, 0, 32'h000, 0); access(1, 0, 32'h004, 0);
    access(1, 1, 32'h000, 32'h1234_5678); access(1, 0, 32'h000, 0);

    // R9: auto-control
    access(1, 1, 32'h0C0, 32'hFFFF_FFFF); access(1, 1, 32'h0E4, 32'h1);
    access(1, 0, 32'h0C0, 0); access(1, 0, 32'h0E4, 0); access(1, 0, 32'h0C4, 0);

    // R10: undefined offsets
    access(1, 0, 32'h100, 0); access(1, 1, 32'h7F8, 32'hFFFF_FFFF);
    access(1, 0, 32'h080, 0);

    // R11 R7: source 4 edge, source 5 level, both unmasked
    access(1, 1, 32'h060, 32'h0000_0010);
    access(1, 1, 32'h020, 32'hFFFF_FFCF);
    cur_irq[4] = 1'b1; idle(); idle();
    cur_irq[4] = 1'b0; idle();
    access(1, 0, 32'h3A0, 0);
    access(1, 1, 32'h080, 32'h0000_0010); idle();
    cur_irq[5] = 1'b1; idle();
    access(1, 1, 32'h080, 32'h0000_0020); idle();
    cur_irq[5] = 1'b0; idle();
    // polarity inversion on edge source 36
    access(1, 1, 32'h064, 32'h0000_0010);
    access(1, 1, 32'h024, 32'hFFFF_FFEF);
    access(1, 1, 32'h3E4, 32'h0000_0010); idle();
    access(1, 0, 32'h3A4, 0);
    access(1, 1, 32'h084, 32'h0000_0010); idle();
    // R6: status write and masked read
    access(1, 1, 32'h3A0, 32'hA5A5_0000);
    access(1, 0, 32'h3A0, 0);
    access(1, 1, 32'h020, 32'hFFFF_FFFF);
    access(1, 0, 32'h3A0, 0);

    // random phase
    offs = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h080, 12'h0C0, 12'h3A0, 12'h3E0, 12'h100};
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      logic [31:0] wd;
      if ($urandom_range(3) == 0) cur_irq[$urandom_range(63)] ^= 1'b1;
      a  = {($urandom_range(3) == 0) ? $urandom() >> 12 : 20'h0,
            offs[$urandom_range(8)] | ($urandom_range(1) << 2)};
      a  = a | (($urandom_range(15) == 0) ? $urandom_range(3) : 0);
      wd = $urandom();
      if ($urandom_range(1) == 0) access(1, $urandom_range(1), a, wd);
      else idle();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule